// File: doc/BRIEF.md
# Negotiation Bit-Clock Divider

This block turns a fast reference clock into a slow, single-cycle timing tick. A serial bus controller uses that tick to pace the bit timing it negotiates on the bus. The division runs as three cascaded stages. The first is a fixed divide by four. The second divides by `4*m + 1`, where `m` is an 8-bit message timing byte. The third divides by `2^e`, where `e` is a 3-bit exponent. The total ratio is therefore `4 * (4*m + 1) * 2^e` reference cycles per tick. Software chooses `m` and `e` for the target bus rate. Rates from about 2 kHz up to 2 MHz are usable, and 1 MHz is the usual setting.

The timing register carries a second byte, the address timing, which software programs to the same value as the message timing. The block compares the two bytes and raises a consistency flag only when they match. Software reads a mismatch as "rate undefined". The divider itself always uses the message timing byte.

A small state machine controls the counters. It has three states:
- `ST_OFF` is the idle state.
- `ST_LOAD` captures the settings.
- `ST_COUNT` is the running state.

The transitions are:
- `OFF->LOAD` occurs when the enable is seen high.
- `LOAD->COUNT` occurs on the following cycle.
- `LOAD->OFF` and `COUNT->OFF` occur whenever the enable is seen low.
- `COUNT->COUNT` is the normal running case. At each terminal count, the working copies of `m` and `e` are reloaded from the inputs.

Top module: `bitclk_div`

## Requirements
- R1: While reset is asserted, and after reset with `run_en` low, `tick_o` stays 0.
- R2: While `run_en` is high, `tick_o` pulses once every `4*(4*m+1)*2^e` reference cycles. The first pulse is seen `4*(4*m+1)*2^e + 1` rising edges after the edge that first samples `run_en` high.
- R3: A message timing value of 0 divides as if it were 1.
- R4: Each `tick_o` pulse is exactly one reference cycle wide.
- R5: Once `run_en` is sampled low, `tick_o` stays 0 from the next cycle on. Raising `run_en` again restarts the count from zero, with the latency of R2.
- R6: A change to `msg_timing` or `div_exp` in the middle of a period leaves that period's length unchanged. The new value sets the length of the following period.
- R7: `timing_ok_o` is 1 exactly when `msg_timing` equals `addr_timing`, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Divider enable (bus clock enable bit) |
| div_exp | input | 3 | Power-of-two stage exponent `e` |
| msg_timing | input | 8 | Message timing byte `m` (linear stage) |
| addr_timing | input | 8 | Address timing byte, compared against `msg_timing` |
| tick_o | output | 1 | One-cycle tick at the divided rate |
| timing_ok_o | output | 1 | High when the two timing bytes agree |

## Verification
The period check in the checker compares each gap between ticks with the ratio computed from the captured working copies of `m` and `e`, and not from the live inputs. It therefore needs no assumption that software holds the timing bytes steady, and the bench deliberately changes them mid-period. The checks assume that `run_en`, `div_exp` and the timing bytes are synchronous to the reference clock. The bench meets this by driving every input on the falling edge. The settings are kept to ratios of a few thousand cycles, so that each scenario finishes well within the run limit.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_LOAD  = 2'd1,
        ST_COUNT = 2'd2
    } div_state_t;

    // Width of the message timing byte and of the exponent field.
    localparam int M_W = 8;
    localparam int E_W = 3;

endpackage

// File: rtl/bitclk_stage.sv
// One modulo counter of the cascade: advances on step, wraps after limit.
module bitclk_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         term
);
    logic [W-1:0] cnt_q;

    assign term = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= term ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bitclk_limits.sv
// Turns the captured settings into terminal values for the linear and
// power-of-two stages.
module bitclk_limits #(
    parameter int M_W   = 8,
    parameter int E_W   = 3,
    localparam int LIN_W = M_W + 2,
    localparam int POW_W = (1 << E_W) - 1
) (
    input  logic [M_W-1:0]   m_val,
    input  logic [E_W-1:0]   e_val,
    output logic [LIN_W-1:0] lin_lim,
    output logic [POW_W-1:0] pow_lim
);
    always_comb begin
        // Modulus 4m+1 means terminal value 4m.
        lin_lim = {m_val, 2'b00};
        // Modulus 2^e means terminal value 2^e - 1 (wraps correctly at e=max).
        pow_lim = (POW_W'(1) << e_val) - POW_W'(1);
    end
endmodule

// File: rtl/bitclk_div.sv
module bitclk_div
    import bitclk_pkg::*;
#(
    parameter int PRE_DIV = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_en,
    input  logic [E_W-1:0] div_exp,
    input  logic [M_W-1:0] msg_timing,
    input  logic [M_W-1:0] addr_timing,
    output logic           tick_o,
    output logic           timing_ok_o
);
    localparam int PRE_W = $clog2(PRE_DIV);
    localparam int LIN_W = M_W + 2;
    localparam int POW_W = (1 << E_W) - 1;

    div_state_t     state_q, state_d;
    logic [M_W-1:0] sh_m_q;
    logic [E_W-1:0] sh_e_q;
    logic [M_W-1:0] m_floor;

    logic [LIN_W-1:0] lin_lim;
    logic [POW_W-1:0] pow_lim;
    logic pre_term, lin_term, pow_term;
    logic wrap, cnt_clr, capture;

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // ---- next state ----
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (run_en) state_d = ST_LOAD;
            ST_LOAD:  state_d = run_en ? ST_COUNT : ST_OFF;
            ST_COUNT: if (!run_en) state_d = ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    // ---- working copies of the settings ----
    assign m_floor = (msg_timing == '0) ? M_W'(1) : msg_timing;
    assign wrap    = pre_term & lin_term & pow_term;
    assign capture = (state_q == ST_LOAD) || ((state_q == ST_COUNT) && wrap);
    assign cnt_clr = (state_q != ST_COUNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_m_q <= M_W'(1);
            sh_e_q <= '0;
        end else if (capture) begin
            sh_m_q <= m_floor;
            sh_e_q <= div_exp;
        end
    end

    bitclk_limits #(.M_W(M_W), .E_W(E_W)) u_limits (
        .m_val   (sh_m_q),
        .e_val   (sh_e_q),
        .lin_lim (lin_lim),
        .pow_lim (pow_lim)
    );

    // ---- three cascaded stages ----
    bitclk_stage #(.W(PRE_W)) u_pre (
        .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .step (1'b1),
        .limit (PRE_W'(PRE_DIV - 1)), .term (pre_term)
    );

    bitclk_stage #(.W(LIN_W)) u_lin (
        .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .step (pre_term),
        .limit (lin_lim), .term (lin_term)
    );

    bitclk_stage #(.W(POW_W)) u_pow (
        .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .step (pre_term & lin_term),
        .limit (pow_lim), .term (pow_term)
    );

    // ---- outputs ----
    always_comb begin
        tick_o      = (state_q == ST_COUNT) && wrap;
        timing_ok_o = (msg_timing == addr_timing);
    end
endmodule

// File: rtl/bitclk_div_chk.sv
module bitclk_div_chk
    import bitclk_pkg::*;
#(
    parameter int GAP_W = 24
) (
    input logic           clk,
    input logic           rst_n,
    input logic           run_en,
    input logic           tick,
    input div_state_t     st,
    input logic [M_W-1:0] sh_m,
    input logic [E_W-1:0] sh_e
);
    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] ratio;

    always_comb begin
        ratio = ((GAP_W'({sh_m, 2'b00}) + GAP_W'(1)) << 2) << sh_e;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      gap_q <= '0;
        else if (st != ST_COUNT || tick) gap_q <= '0;
        else                             gap_q <= gap_q + 1'b1;
    end

    // R2 / R6: tick lands exactly one full ratio after load or the last tick
    p_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q == ratio - GAP_W'(1)));

    // R3: the working message timing is never zero while counting
    p_m_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COUNT) |-> (sh_m != '0));

    // R4: single-cycle pulse
    p_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R5: enable low silences the tick from the next cycle
    p_quiet_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !tick);

    // R6: settings only move at a terminal count or a load
    p_hold_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COUNT && !tick) |=> ($stable(sh_m) && $stable(sh_e)));
endmodule

bind bitclk_div bitclk_div_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (run_en),
    .tick   (tick_o),
    .st     (state_q),
    .sh_m   (sh_m_q),
    .sh_e   (sh_e_q)
);

// File: tb/tb_bitclk_div.sv
module tb_bitclk_div;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [2:0] div_exp = 3'd0;
    logic [7:0] msg_timing = 8'd1;
    logic [7:0] addr_timing = 8'd1;
    logic       tick_o;
    logic       timing_ok_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bitclk_div dut (
        .clk (clk), .rst_n (rst_n), .run_en (run_en), .div_exp (div_exp),
        .msg_timing (msg_timing), .addr_timing (addr_timing),
        .tick_o (tick_o), .timing_ok_o (timing_ok_o)
    );

    function automatic int ratio(input int m, input int e);
        int mm = (m == 0) ? 1 : m;
        return 4 * (4 * mm + 1) * (1 << e);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // counts rising edges until tick_o is seen high at a falling edge
    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!tick_o && n < 20000);
    endtask

    task automatic set_cfg(input int m, input int e);
        msg_timing  = 8'(m);
        addr_timing = 8'(m);
        div_exp     = 3'(e);
    endtask

    task automatic t_reset;
        int seen = 0;
        chk(tick_o == 1'b0, "R1 in reset", tick_o, 0);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (tick_o) seen++;
        end
        chk(seen == 0, "R1 idle after reset", seen, 0);
    endtask

    task automatic t_rate(input int m, input int e, input string req);
        int n;
        @(negedge clk); run_en = 1'b0; set_cfg(m, e);
        @(negedge clk); @(negedge clk);
        run_en = 1'b1;
        wait_tick(n);
        chk(n == ratio(m, e) + 1, {req, " first latency"}, n, ratio(m, e) + 1);
        @(negedge clk);
        chk(tick_o == 1'b0, "R4 width", tick_o, 0);
        wait_tick(n);
        chk(n == ratio(m, e) - 1, {req, " gap"}, n + 1, ratio(m, e));
    endtask

    task automatic t_disable;
        int seen = 0, n;
        set_cfg(1, 0);
        @(negedge clk); run_en = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (tick_o) seen++;
        end
        chk(seen == 0, "R5 silent when disabled", seen, 0);
        run_en = 1'b1;
        wait_tick(n);
        chk(n == ratio(1, 0) + 1, "R5 restart latency", n, ratio(1, 0) + 1);
    endtask

    task automatic t_midchange;
        int n, k;
        @(negedge clk); run_en = 1'b0; set_cfg(1, 0);
        @(negedge clk); run_en = 1'b1;
        wait_tick(n);
        n = 0;
        repeat (5) begin @(posedge clk); @(negedge clk); n++; end
        set_cfg(2, 1);
        wait_tick(k);
        chk(n + k == ratio(1, 0), "R6 current period kept", n + k, ratio(1, 0));
        wait_tick(k);
        chk(k == ratio(2, 1), "R6 next period new", k, ratio(2, 1));
    endtask

    task automatic t_consistency;
        @(negedge clk); msg_timing = 8'h40; addr_timing = 8'h40;
        #1 chk(timing_ok_o == 1'b1, "R7 equal bytes", timing_ok_o, 1);
        addr_timing = 8'h41;
        #1 chk(timing_ok_o == 1'b0, "R7 differing bytes", timing_ok_o, 0);
        msg_timing = 8'h00; addr_timing = 8'h80;
        #1 chk(timing_ok_o == 1'b0, "R7 differing high bit", timing_ok_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_rate(1, 0, "R2 m=1 e=0");
        t_rate(3, 2, "R2 m=3 e=2");
        t_rate(2, 7, "R2 e=7");
        t_rate(255, 0, "R2 m=255");
        t_rate(0, 1, "R3 m=0");
        t_disable();
        t_midchange();
        t_consistency();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual expired expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule